// File: doc/BRIEF.md
# Protected Domain Access Gate

This block guards a small battery-backed storage area that sits on a fast system bus. The area holds 16 words of 32 bits plus an 8-bit control field. Reads and writes reach it only while an unlock bit is set. That bit lives in a power-control register on a slower peripheral bus, so the gate receives it as an asynchronous level and passes it through a two-flop synchronizer first. Only the synchronized value decides whether an access goes through. A write that has not yet landed in the power-control register therefore has no effect on the gate.

An access that is refused is never reported as an error. A refused write is dropped. A refused read returns zero. Every request gets a ready pulse one cycle later, whether or not it was allowed. The storage and the control field have no reset, so their contents survive a reset of the fast-bus logic.

Top module: `bkp_gate`

## Requirements
- R1: A write to a storage word (addr_i 0 to 15) or to the control field (addr_i 16) is stored only when the synchronized unlock value is 1 at the sampling edge. When that value is 0, the write is discarded and the stored contents stay unchanged.
- R2: A read that is sampled while the synchronized unlock value is 0 completes normally and returns rdata_o = 0.
- R3: Every request sampled at a rising edge gives rdy_o = 1 for exactly the following cycle, whether it was allowed or refused. rdy_o is 0 after a cycle with no request and while rst_ni is low. rdata_o is 0 on the completion of a write.
- R4: unlock_i passes through two flops that reset to 0. An access sampled at the first or second rising edge after unlock_i changes still sees the old value. An access sampled at the third edge or later sees the new value.
- R5: In a permitted write, be_i[k] enables data bits 8k+7 to 8k. Bytes whose strobe is 0 keep their old value. For the control field, this means only be_i[0] matters.
- R6: The storage words and the control field keep their contents across an assertion of rst_ni.
- R7: Address map, with addr_i as a 5-bit word address: addr_i[4] = 0 selects storage word addr_i[3:0]. Address 16 selects the control field, which reads back zero-extended in bits 7 to 0. Addresses 17 to 31 always read 0, and writes to them change nothing.
- R8: ctrl_o always shows the current control field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the bus logic |
| unlock_i | input | 1 | Unlock bit from the slow-domain power-control register (asynchronous) |
| req_i | input | 1 | Access request, sampled at each rising edge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte write strobes |
| rdy_o | output | 1 | Completion pulse, one cycle after the request |
| rdata_o | output | 32 | Read data, valid while rdy_o is 1 |
| ctrl_o | output | 8 | Current control field |

## Verification
The bench uses the default parameters: 16 words of 32 bits, an 8-bit control field and a two-stage synchronizer. With these values, all 32 addresses and all 16 strobe combinations fit in a short run. Every storage word is written and read back both locked and unlocked, and the reserved addresses are checked for aliasing into storage. Accesses are placed on the first, second and third edge after unlock_i rises and after it falls, which checks the synchronizer latency in both directions. A reset in the middle of the run shows that the contents are retained and that the enable drops back to locked.

// File: rtl/bkp_gate_pkg.sv
package bkp_gate_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_WORD = 2'd1,
    SEL_CTRL = 2'd2
  } sel_e;
endpackage

// File: rtl/bkp_sync.sv
module bkp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/bkp_decode.sv
module bkp_decode
  import bkp_gate_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int IDX_W  = $clog2(WORDS),
  parameter int ADDR_W = IDX_W + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    if (addr_i < ADDR_W'(WORDS))       sel_o = SEL_WORD;
    else if (addr_i == ADDR_W'(WORDS)) sel_o = SEL_CTRL;
    else                               sel_o = SEL_NONE;
  end

  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/bkp_store.sv
// No reset: contents are battery-backed and outlive bus-logic reset.
module bkp_store #(
  parameter int WORDS  = 16,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int IDX_W  = $clog2(WORDS),
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              wr_word_i,
  input  logic              wr_ctrl_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] bit_mask;

  for (genvar b = 0; b < BE_W; b++) begin : g_mask
    assign bit_mask[b*8 +: 8] = {8{be_i[b]}};
  end

  always_ff @(posedge clk_i) begin
    if (wr_word_i)
      mem_q[idx_i] <= (mem_q[idx_i] & ~bit_mask) | (wdata_i & bit_mask);
  end

  always_ff @(posedge clk_i) begin
    if (wr_ctrl_i)
      ctrl_q <= (ctrl_q & ~bit_mask[CTRL_W-1:0]) | (wdata_i[CTRL_W-1:0] & bit_mask[CTRL_W-1:0]);
  end

  assign rd_word_o = mem_q[idx_i];
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/bkp_gate.sv
module bkp_gate
  import bkp_gate_pkg::*;
#(
  parameter int WORDS       = 16,
  parameter int DATA_W      = 32,
  parameter int CTRL_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(WORDS),
  localparam int ADDR_W     = IDX_W + 1,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              unlock_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic              unlock_sync;
  sel_e              sel;
  logic [IDX_W-1:0]  idx;
  logic              allow;
  logic              wr_word;
  logic              wr_ctrl;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rd_mux;
  logic              rdy_q;
  logic [DATA_W-1:0] rdata_q;

  bkp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (unlock_i),
    .q_o    (unlock_sync)
  );

  bkp_decode #(.WORDS(WORDS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel),
    .idx_o  (idx)
  );

  assign allow   = req_i & unlock_sync;
  assign wr_word = allow & we_i & (sel == SEL_WORD);
  assign wr_ctrl = allow & we_i & (sel == SEL_CTRL);

  bkp_store #(
    .WORDS(WORDS), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .IDX_W(IDX_W), .BE_W(BE_W)
  ) u_store (
    .clk_i     (clk_i),
    .wr_word_i (wr_word),
    .wr_ctrl_i (wr_ctrl),
    .idx_i     (idx),
    .wdata_i   (wdata_i),
    .be_i      (be_i),
    .rd_word_o (rd_word),
    .ctrl_o    (ctrl_o)
  );

  always_comb begin
    unique case (sel)
      SEL_WORD: rd_mux = rd_word;
      SEL_CTRL: rd_mux = DATA_W'(ctrl_o);
      default:  rd_mux = '0;
    endcase
  end

  // Refused accesses still complete; reads return zero.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdy_q   <= req_i;
      rdata_q <= (allow && !we_i) ? rd_mux : '0;
    end
  end

  assign rdy_o   = rdy_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/bkp_gate_chk.sv
module bkp_gate_chk #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              unlock_i,
  input logic              unlock_sync,
  input logic              req_i,
  input logic              we_i,
  input logic              rdy_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [CTRL_W-1:0] ctrl_o
);
  assert_rdy_follows_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rdy_o);

  assert_no_stray_rdy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rdy_o);

  assert_write_rdata_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> (rdata_o == '0));

  assert_locked_read_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !unlock_sync) |=> (rdata_o == '0));

  assert_ctrl_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && unlock_sync) |=> $stable(ctrl_o));

  assert_sync_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlock_sync) |-> $past(unlock_i));

  assert_sync_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(unlock_sync) |-> !$past(unlock_i));
endmodule

bind bkp_gate bkp_gate_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .unlock_i    (unlock_i),
  .unlock_sync (unlock_sync),
  .req_i       (req_i),
  .we_i        (we_i),
  .rdy_o       (rdy_o),
  .rdata_o     (rdata_o),
  .ctrl_o      (ctrl_o)
);

// File: tb/bkp_gate_bench.sv
module bkp_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        unlock_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  be_i = '0;
  logic        rdy_o;
  logic [31:0] rdata_o;
  logic [7:0]  ctrl_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] mem_exp [WORDS];
  logic [7:0]  ctrl_exp;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bkp_gate u_bkp_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .unlock_i(unlock_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i),
    .rdy_o(rdy_o), .rdata_o(rdata_o), .ctrl_o(ctrl_o)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'h9E37_79B9 * (i + 3);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (be[k]) r[k*8 +: 8] = d[k*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the completion sampled.
  task automatic bus(input logic we, input logic [4:0] a, input logic [31:0] d,
                     input logic [3:0] be, output logic [31:0] rd);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk_i);
    check(rdy_o === 1'b1, "R3 rdy after request", 32'(rdy_o), 32'd1);
    if (we) check(rdata_o === 32'h0, "R3 write rdata zero", rdata_o, 32'h0);
    rd = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] dummy;
    bus(1'b1, a, d, be, dummy);
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] r;
    bus(1'b0, a, 32'h0, 4'h0, r);
    check(r === exp, tag, r, exp);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(rdy_o === 1'b0, "R3 rdy low in reset", 32'(rdy_o), 32'd0);
    check(rdata_o === 32'h0, "R3 rdata zero in reset", rdata_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: locked reads return zero
    rd_chk(5'd0, 32'h0, "R2 locked read word 0");
    rd_chk(5'd16, 32'h0, "R2 locked read ctrl");
    @(negedge clk_i);
    check(rdy_o === 1'b0, "R3 no rdy without request", 32'(rdy_o), 32'd0);

    // R1/R7: unlocked fill and read-back of every word
    unlock_i = 1'b1;
    settle();
    for (int i = 0; i < WORDS; i++) begin
      wr(5'(i), pat(i), 4'hF);
      mem_exp[i] = pat(i);
    end
    for (int i = 0; i < WORDS; i++) rd_chk(5'(i), mem_exp[i], "R1 unlocked read-back");

    // R7/R8: control field
    wr(5'd16, 32'hFFFF_FF3C, 4'hF);
    ctrl_exp = 8'h3C;
    check(ctrl_o === ctrl_exp, "R8 ctrl_o after write", 32'(ctrl_o), 32'(ctrl_exp));
    rd_chk(5'd16, 32'(ctrl_exp), "R7 ctrl reads zero-extended");

    // R5: every strobe pattern on word 5
    for (int be = 0; be < 16; be++) begin
      logic [31:0] d = 32'h0101_0101 * (be + 17);
      wr(5'd5, d, 4'(be));
      mem_exp[5] = merge(mem_exp[5], d, 4'(be));
      rd_chk(5'd5, mem_exp[5], "R5 byte strobes");
    end
    wr(5'd16, 32'h0000_00C3, 4'b1110);
    check(ctrl_o === ctrl_exp, "R5 ctrl ignores upper strobes", 32'(ctrl_o), 32'(ctrl_exp));

    // R7: reserved addresses
    for (int a = 17; a < 32; a++) begin
      wr(5'(a), 32'hDEAD_0000 | a, 4'hF);
      rd_chk(5'(a), 32'h0, "R7 reserved reads zero");
    end
    for (int i = 0; i < WORDS; i++) rd_chk(5'(i), mem_exp[i], "R7 no alias from reserved");
    check(ctrl_o === ctrl_exp, "R7 ctrl untouched by reserved", 32'(ctrl_o), 32'(ctrl_exp));

    // R1/R2: locked writes dropped, locked reads zero
    unlock_i = 1'b0;
    settle();
    for (int i = 0; i < WORDS; i++) wr(5'(i), ~pat(i), 4'hF);
    wr(5'd16, 32'h55, 4'hF);
    check(ctrl_o === ctrl_exp, "R1 locked ctrl write dropped", 32'(ctrl_o), 32'(ctrl_exp));
    for (int i = 0; i < WORDS; i++) rd_chk(5'(i), 32'h0, "R2 locked read zero");
    unlock_i = 1'b1;
    settle();
    for (int i = 0; i < WORDS; i++) rd_chk(5'(i), mem_exp[i], "R1 locked writes discarded");

    // R4: rising unlock, accesses on edges 1, 2, 3
    unlock_i = 1'b0;
    settle();
    unlock_i = 1'b1;
    wr(5'd7, 32'hA000_0007, 4'hF);
    wr(5'd8, 32'hA000_0008, 4'hF);
    wr(5'd9, 32'hA000_0009, 4'hF);
    mem_exp[9] = 32'hA000_0009;
    rd_chk(5'd7, mem_exp[7], "R4 edge1 after rise still locked");
    rd_chk(5'd8, mem_exp[8], "R4 edge2 after rise still locked");
    rd_chk(5'd9, mem_exp[9], "R4 edge3 after rise unlocked");

    // R4: falling unlock
    unlock_i = 1'b0;
    wr(5'd10, 32'hB000_000A, 4'hF);
    wr(5'd11, 32'hB000_000B, 4'hF);
    wr(5'd12, 32'hB000_000C, 4'hF);
    mem_exp[10] = 32'hB000_000A;
    mem_exp[11] = 32'hB000_000B;
    unlock_i = 1'b1;
    settle();
    rd_chk(5'd10, mem_exp[10], "R4 edge1 after fall still unlocked");
    rd_chk(5'd11, mem_exp[11], "R4 edge2 after fall still unlocked");
    rd_chk(5'd12, mem_exp[12], "R4 edge3 after fall locked");

    // R6: retention across reset; R4: sync restarts locked
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check(rdy_o === 1'b0, "R3 rdy low in second reset", 32'(rdy_o), 32'd0);
    rst_ni = 1'b1;
    rd_chk(5'd3, 32'h0, "R4 sync cleared by reset");
    settle();
    for (int i = 0; i < WORDS; i++) rd_chk(5'(i), mem_exp[i], "R6 word retained");
    check(ctrl_o === ctrl_exp, "R6 ctrl retained", 32'(ctrl_o), 32'(ctrl_exp));

    finish_run();
  end
endmodule